// File: doc/BRIEF.md
# Line Signal Detect Qualifier

This block decides whether a real signal is present on the receive pair of a 10/100 Mb/s transceiver. It watches single-cycle strobes from the line comparator, one for each valid pulse, plus a flag that says Manchester data is being decoded at 10 Mb/s. It raises a registered signal-detect flag once enough pulses arrive close together. That flag then drives three control outputs. One moves the comparator threshold from the high squelch level down to the lower unsquelch level. One lets the adaptive circuits leave their initial state. One points the clock recovery loop at the received line signal instead of the local transmit clock.

How detect is dropped depends on the speed select. At 100 Mb/s an idle timer clocked from the 25 MHz reference drops the flag after 30 cycles (about 1.2 µs) without a pulse. At 10 Mb/s the flag drops as soon as the Manchester-valid input goes low. Before detect, the same idle timer discards a lone pulse, so isolated noise spikes never qualify. The pulse count always starts again from zero after detect is lost.

Top module: `line_sigdet`

## Requirements
- R1: While detect is low, the valid pulse that brings the count of pulses to 2 raises sig_detect_o at the clock edge where that pulse is sampled. Each pulse must arrive before the idle timer expires.
- R2: thresh_low_o is 1, selecting the unsquelch level, exactly while sig_detect_o is 1. It is 0, selecting the squelch level, otherwise.
- R3: adapt_release_o is 1 exactly while sig_detect_o is 1.
- R4: With speed_100_i = 1 and detect high, sig_detect_o falls at the 30th consecutive edge with no pulse after the last pulse. A pulse sampled at that 30th edge keeps detect high and restarts the 30-cycle window.
- R5: With speed_100_i = 0 and detect high, sig_detect_o falls at the first edge that samples manch_valid_i = 0. Pulses sampled at that edge do not prevent the fall.
- R6: While detect is low, 30 consecutive pulse-free edges after a pulse clear the pending pulse count, at either speed. A single pulse followed by that timeout never raises detect.
- R7: cdr_use_line_o is 1, selecting the received line as the clock reference, exactly while sig_detect_o is 1. It is 0, selecting the local transmit serial clock, otherwise.
- R8: Pulses sampled while detect is high, including at the edge where it falls, are not counted. After a fall, two fresh pulses are needed to raise detect again.
- R9: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_valid_i | input | 1 | One-cycle strobe per valid line pulse |
| manch_valid_i | input | 1 | Manchester data currently decoded (10 Mb/s) |
| speed_100_i | input | 1 | 1 = 100 Mb/s rules, 0 = 10 Mb/s rules |
| sig_detect_o | output | 1 | Qualified signal-detect flag |
| thresh_low_o | output | 1 | 1 = unsquelch (lower) threshold, 0 = squelch |
| adapt_release_o | output | 1 | Releases adaptive circuits from their initial state |
| cdr_use_line_o | output | 1 | 1 = clock recovery follows line, 0 = transmit clock |

## Verification
Two events can fall on the same edge: a pulse arriving and the idle timer expiring. Before detect, this is the second pulse landing exactly on the 30th idle edge. After detect at 100 Mb/s, it is a refresh pulse landing on that edge. Directed sequences place the pulse on the 29th, 30th and 31st edge after the previous one. The rule is that a pulse on the expiry edge always wins: it qualifies or keeps detect, while a pulse one edge later finds the count cleared or detect already dropped. Random stimulus that mixes both speeds compares every edge against a bench model built from the requirements.

// File: rtl/sigdet_pkg.sv
package sigdet_pkg;

    localparam int unsigned DEF_IDLE_LIMIT = 30;
    localparam int unsigned DEF_PULSES_REQ = 2;

    typedef enum logic {
        SPEED_10M  = 1'b0,
        SPEED_100M = 1'b1
    } speed_e;

    typedef enum logic {
        LVL_SQUELCH   = 1'b0,
        LVL_UNSQUELCH = 1'b1
    } level_e;

    typedef enum logic {
        REF_TX_CLOCK = 1'b0,
        REF_LINE     = 1'b1
    } cdr_ref_e;

endpackage

// File: rtl/sigdet_idle_timer.sv
module sigdet_idle_timer #(
    parameter int unsigned IDLE_LIMIT = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    output logic expire_o
);
    localparam int unsigned TW = $clog2(IDLE_LIMIT + 1);
    localparam logic [TW-1:0] LOAD_VAL = TW'(IDLE_LIMIT);

    typedef struct packed {
        logic [TW-1:0] left;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pulse_i) begin
            st_d.left = LOAD_VAL;
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - 1'b1;
        end
        expire_o = (st_q.left == TW'(1)) && !pulse_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4 / R6: every pulse reloads the full idle window
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_i |=> (st_q.left == LOAD_VAL));

    // R6: the timer never goes above its load value
    a_r6_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.left <= LOAD_VAL);

endmodule

// File: rtl/sigdet_pulse_cnt.sv
module sigdet_pulse_cnt #(
    parameter int unsigned PULSES_REQ = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    input  logic clear_i,
    output logic reach_o
);
    localparam int unsigned CW = $clog2(PULSES_REQ + 1);
    localparam logic [CW-1:0] LAST = CW'(PULSES_REQ - 1);

    typedef struct packed {
        logic [CW-1:0] seen;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        reach_o = 1'b0;
        if (clear_i) begin
            st_d.seen = '0;
        end else if (pulse_i) begin
            if (st_q.seen == LAST) begin
                reach_o   = 1'b1;
                st_d.seen = '0;
            end else begin
                st_d.seen = st_q.seen + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: a clear request leaves nothing pending
    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_q.seen == '0));

    // R1: the pending count never reaches the required number
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seen <= LAST);

endmodule

// File: rtl/sigdet_ctrl.sv
module sigdet_ctrl
    import sigdet_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    input  logic manch_i,
    input  logic speed_i,
    input  logic expire_i,
    input  logic reach_i,
    output logic clear_o,
    output logic det_o
);
    typedef struct packed {
        logic det;
    } ctl_t;

    ctl_t   st_d, st_q;
    speed_e spd;
    logic   drop;

    always_comb begin
        spd     = speed_e'(speed_i);
        drop    = (spd == SPEED_100M) ? expire_i : !manch_i;
        st_d    = st_q;
        clear_o = st_q.det || expire_i;
        if (st_q.det) begin
            if (drop) st_d.det = 1'b0;
        end else if (reach_i) begin
            st_d.det = 1'b1;
        end
        det_o = st_q.det;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: detect only rises at an edge that sampled a pulse
    a_r1_rise_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.det && st_d.det) |-> pulse_i);

    // R4: 100 Mb/s idle expiry drops detect
    a_r4_timeout_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.det && speed_i && expire_i) |=> !st_q.det);

    // R5: 10 Mb/s loss of Manchester data drops detect
    a_r5_manch_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.det && !speed_i && !manch_i) |=> !st_q.det);

    // R6: expiry while waiting never raises detect
    a_r6_no_rise_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.det && expire_i) |=> !st_q.det);

endmodule

// File: rtl/line_sigdet.sv
module line_sigdet
    import sigdet_pkg::*;
#(
    parameter int unsigned IDLE_LIMIT = DEF_IDLE_LIMIT,
    parameter int unsigned PULSES_REQ = DEF_PULSES_REQ
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_valid_i,
    input  logic manch_valid_i,
    input  logic speed_100_i,
    output logic sig_detect_o,
    output logic thresh_low_o,
    output logic adapt_release_o,
    output logic cdr_use_line_o
);
    logic expire, reach, clear, det;

    sigdet_idle_timer #(.IDLE_LIMIT(IDLE_LIMIT)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_i  (pulse_valid_i),
        .expire_o (expire)
    );

    sigdet_pulse_cnt #(.PULSES_REQ(PULSES_REQ)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (pulse_valid_i),
        .clear_i (clear),
        .reach_o (reach)
    );

    sigdet_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_i  (pulse_valid_i),
        .manch_i  (manch_valid_i),
        .speed_i  (speed_100_i),
        .expire_i (expire),
        .reach_i  (reach),
        .clear_o  (clear),
        .det_o    (det)
    );

    level_e   lvl;
    cdr_ref_e ref_sel;

    always_comb begin
        lvl     = det ? LVL_UNSQUELCH : LVL_SQUELCH;
        ref_sel = det ? REF_LINE : REF_TX_CLOCK;
    end

    assign sig_detect_o    = det;
    assign thresh_low_o    = (lvl == LVL_UNSQUELCH);
    assign adapt_release_o = det;
    assign cdr_use_line_o  = (ref_sel == REF_LINE);

    // R9: outputs are quiet during reset
    a_r9_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !sig_detect_o);

endmodule

// File: tb/line_sigdet_bench.sv
module line_sigdet_bench;
    localparam int IDLE = 30;
    localparam int REQ  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pulse = 1'b0, manch = 1'b0, spd = 1'b1;
    logic det, thr, adp, cdr;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    int  m_idle = 0;
    int  m_cnt = 0;
    bit  m_det = 0;

    always #2.5 clk = ~clk;

    line_sigdet u_line_sigdet (
        .clk(clk), .rst_n(rst_n), .pulse_valid_i(pulse),
        .manch_valid_i(manch), .speed_100_i(spd),
        .sig_detect_o(det), .thresh_low_o(thr),
        .adapt_release_o(adp), .cdr_use_line_o(cdr)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic void model(input bit p, input bit m, input bit s);
        bit expire, drop, nd;
        int nc;
        expire = (m_idle == 1) && !p;
        drop   = s ? expire : !m;
        nd = m_det;
        nc = m_cnt;
        if (m_det || expire) nc = 0;
        else if (p) begin
            if (m_cnt == REQ - 1) begin nd = 1; nc = 0; end
            else nc = m_cnt + 1;
        end
        if (m_det && drop) nd = 0;
        m_det = nd;
        m_cnt = nc;
        m_idle = p ? IDLE : (m_idle > 0 ? m_idle - 1 : 0);
    endfunction

    task automatic step(input bit p, input bit m, input bit s);
        @(negedge clk);
        pulse = p; manch = m; spd = s;
        @(posedge clk);
        model(p, m, s);
        #1;
        chk("R1 R4 R5 det", det, m_det);
        chk("R2 thresh", thr, m_det);
        chk("R3 adapt", adp, m_det);
        chk("R7 cdr", cdr, m_det);
    endtask

    task automatic idle(input int n, input bit m, input bit s);
        for (int i = 0; i < n; i++) step(0, m, s);
    endtask

    initial begin
        int wd = 0;
        while (wd < 150000 && !done) begin @(posedge clk); wd++; end
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset det", det, 1'b0);
        chk("R9 reset thr", thr, 1'b0);
        chk("R9 reset adp", adp, 1'b0);
        chk("R9 reset cdr", cdr, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        // R6: lone pulse then timeout, then one more pulse: never detect
        step(1, 0, 1); idle(30, 0, 1);
        chk("R6 lone pulse", det, 1'b0);
        step(1, 0, 1);
        chk("R6 after expiry", det, 1'b0);
        // R1: second pulse on the 30th idle edge still qualifies
        idle(29, 0, 1); step(1, 0, 1);
        chk("R1 second pulse on expiry edge", det, 1'b1);
        // R4: refresh on the 30th edge keeps detect
        idle(29, 0, 1);
        chk("R4 29 idle edges", det, 1'b1);
        step(1, 0, 1);
        chk("R4 refresh on 30th", det, 1'b1);
        idle(29, 0, 1);
        chk("R4 still high at 29", det, 1'b1);
        step(0, 0, 1);
        chk("R4 drop at 30", det, 1'b0);
        chk("R2 squelch after drop", thr, 1'b0);
        // R8: one pulse after drop does not re-qualify
        step(1, 0, 1);
        chk("R8 single pulse after drop", det, 1'b0);
        step(1, 0, 1);
        chk("R1 two pulses", det, 1'b1);
        chk("R7 line ref", cdr, 1'b1);
        // R5: 10 Mb/s, pulse on same edge as manchester loss
        step(0, 1, 0); idle(40, 1, 0);
        chk("R5 holds with manchester", det, 1'b1);
        step(1, 0, 0);
        chk("R5 drop on manchester loss", det, 1'b0);
        step(1, 0, 0);
        chk("R8 restart count", det, 1'b0);
        idle(35, 0, 0);

        // random phase
        begin
            bit s = 1;
            bit m = 0;
            int dens = 8;
            for (int i = 0; i < 6000; i++) begin
                if (i % 300 == 0) begin s = $urandom_range(0, 1); dens = $urandom_range(3, 40); end
                if ($urandom_range(0, 25) == 0) m = !m;
                step(($urandom_range(0, dens - 1) == 0), m, s);
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule